// File: doc/BRIEF.md
# Host Bus Decoder for a Polled Network Adapter

This block sits between a small CPU's 16-bit address bus and a network adapter's frame buffers and control logic. It watches the address together with separate read and write strobes. From them it drives the buffer enables, returns register contents on a byte-wide read bus, and issues one-clock command pulses to the receiver and the transmitter. The adapter has no interrupt line, so software polls a status byte to learn when a frame has arrived or when a transmission has finished.

Every address the block answers to lies in the top 4 KiB page (upper nibble all ones). The lower half of that page, 0xF000 to 0xF7FF, is one shared buffer window. The direction of the access picks the buffer: a write lands in the transmit buffer and a read comes from the receive buffer. The page 0xFBxx holds the registers. Reads there return status or the received length. Writes to the first two offsets are commands, and their data byte is never looked at.

A small state machine turns the write strobe into command pulses. It has three states. CMD_IDLE moves to CMD_FIRE when a write hits a command address. CMD_FIRE lasts exactly one clock and drives the pulse. From there it moves to CMD_HOLD if the strobe is still high, or back to CMD_IDLE if the strobe has dropped. CMD_HOLD returns to CMD_IDLE once the strobe drops.

Top module: `nic_host_if`

## Requirements
- R1: When the upper address nibble is not 0xF, no buffer enable, no activity indicator and no command pulse is produced, and `host_rdata` is 0.
- R2: A write strobe with an address in 0xF000–0xF7FF (bit 11 = 0) asserts `txbuf_we` in the same cycle.
- R3: A read strobe with an address in 0xF000–0xF7FF asserts `rxbuf_oe` in the same cycle.
- R4: `buf_act` is high exactly when a read or write strobe targets the buffer window. It stays low for register-page accesses.
- R5: A read of 0xFB00 returns the status byte. Bit 0 is `rx_full`, bit 1 is `tx_busy`, and bits 7..2 are 0.
- R6: A read of 0xFB02 returns `rx_len[7:0]` and a read of 0xFB03 returns `rx_len[15:8]`.
- R7: A read at any other 0xFBxx offset, any 0xF8xx–0xFFxx address outside page 0xB, or any cycle without a read strobe gives `host_rdata` = 0.
- R8: A write to 0xFB00 sampled at a clock edge makes `rx_rearm` high for the following cycle. A write to 0xFB01 does the same for `tx_start`. The two pulses are never high together.
- R9: A write strobe held over several cycles produces a single pulse. No further pulse is issued until the strobe has been low at a clock edge.
- R10: Writes to 0xFB02 and above, and reads of 0xFB00/0xFB01, produce no command pulse.
- R11: While `rst_n` is low, and in the first cycle after it rises, both command pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | CPU address bus |
| host_wr | input | 1 | CPU write strobe, active high |
| host_rd | input | 1 | CPU read strobe, active high |
| rx_full | input | 1 | Receiver holds a complete frame |
| tx_busy | input | 1 | Transmitter is sending |
| rx_len | input | 16 | Length of the received frame |
| txbuf_we | output | 1 | Write enable for the transmit buffer |
| rxbuf_oe | output | 1 | Output enable for the receive buffer |
| buf_act | output | 1 | Buffer window access indicator |
| host_rdata | output | 8 | Register read data |
| rx_rearm | output | 1 | One-cycle receiver re-arm pulse |
| tx_start | output | 1 | One-cycle transmit start pulse |

## Verification
The bench goes after the page boundaries first. Addresses 0xF7FF and 0xF800 must fall on opposite sides of the window, and a decoder that tests bit 11 wrongly would enable a buffer for register traffic. It also checks that 0xEBxx is ignored, which catches a decoder that forgets the upper nibble. Held write strobes and back-to-back writes to different command offsets show whether a pulse is re-issued or stretched; a design without the hold state would fire on every cycle of a long strobe. The unused register offsets and reads of the command addresses check that status and length bytes do not leak onto the bus and that reads never trigger commands.

// File: rtl/nic_host_pkg.sv
package nic_host_pkg;

    // Command pulse state machine
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_FIRE = 2'd1,
        CMD_HOLD = 2'd2
    } cmd_state_e;

    // Which command is being issued
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_REARM = 2'd1,
        OP_START = 2'd2
    } cmd_op_e;

    // Address map constants (nibble values and register offsets)
    localparam logic [3:0] PAGE_NIB   = 4'hF;
    localparam logic [3:0] REG_NIB    = 4'hB;
    localparam int         OFF_STATUS = 0;
    localparam int         OFF_START  = 1;
    localparam int         OFF_LEN    = 2;

endpackage

// File: rtl/nic_addr_decode.sv
module nic_addr_decode #(
    parameter int ADDR_W = 16,
    localparam int OFF_W = ADDR_W - 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              in_reg,
    output logic [OFF_W-1:0]  reg_off
);
    import nic_host_pkg::*;

    localparam int NIB_HI = ADDR_W - 1;
    localparam int NIB_LO = ADDR_W - 4;
    localparam int SUB_HI = ADDR_W - 5;
    localparam int SUB_LO = ADDR_W - 8;

    logic page_hit;

    always_comb begin
        page_hit = (addr[NIB_HI:NIB_LO] == PAGE_NIB);
        in_win   = page_hit && !addr[SUB_HI];
        in_reg   = page_hit && (addr[SUB_HI:SUB_LO] == REG_NIB);
        reg_off  = addr[OFF_W-1:0];
    end

endmodule

// File: rtl/nic_reg_rdmux.sv
module nic_reg_rdmux #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8,
    localparam int LEN_W  = 2 * DATA_W,
    localparam int NBYTES = LEN_W / DATA_W
) (
    input  logic              rd_sel,
    input  logic [OFF_W-1:0]  off,
    input  logic              rx_full,
    input  logic              tx_busy,
    input  logic [LEN_W-1:0]  rx_len,
    output logic [DATA_W-1:0] rdata
);
    import nic_host_pkg::*;

    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            if (off == OFF_W'(OFF_STATUS)) begin
                rdata[0] = rx_full;
                rdata[1] = tx_busy;
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (off == OFF_W'(OFF_LEN + i))
                    rdata = rx_len[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/nic_cmd_fsm.sv
module nic_cmd_fsm #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             reg_sel,
    input  logic [OFF_W-1:0] off,
    output logic             rearm,
    output logic             start
);
    import nic_host_pkg::*;

    cmd_state_e state_q, state_d;
    cmd_op_e    op_q, op_d;
    cmd_op_e    hit_op;

    always_comb begin
        hit_op = OP_NONE;
        if (wr && reg_sel) begin
            if (off == OFF_W'(OFF_STATUS))     hit_op = OP_REARM;
            else if (off == OFF_W'(OFF_START)) hit_op = OP_START;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            op_q    <= OP_NONE;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (hit_op != OP_NONE) begin
                    state_d = CMD_FIRE;
                    op_d    = hit_op;
                end
            end
            CMD_FIRE: state_d = wr ? CMD_HOLD : CMD_IDLE;
            CMD_HOLD: if (!wr) state_d = CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rearm = (state_q == CMD_FIRE) && (op_q == OP_REARM);
        start = (state_q == CMD_FIRE) && (op_q == OP_START);
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMD_FIRE) |=> (state_q != CMD_FIRE));

    // R8
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMD_FIRE) |-> $past(wr && reg_sel));

    // R9
    hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMD_HOLD) |-> $past(wr));

endmodule

// File: rtl/nic_host_if.sv
module nic_host_if #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int OFF_W = ADDR_W - 8,
    localparam int LEN_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              rx_full,
    input  logic              tx_busy,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              txbuf_we,
    output logic              rxbuf_oe,
    output logic              buf_act,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rx_rearm,
    output logic              tx_start
);
    logic             in_win;
    logic             in_reg;
    logic [OFF_W-1:0] reg_off;

    nic_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (host_addr),
        .in_win  (in_win),
        .in_reg  (in_reg),
        .reg_off (reg_off)
    );

    nic_reg_rdmux #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_rdmux (
        .rd_sel  (in_reg && host_rd),
        .off     (reg_off),
        .rx_full (rx_full),
        .tx_busy (tx_busy),
        .rx_len  (rx_len),
        .rdata   (host_rdata)
    );

    nic_cmd_fsm #(.OFF_W(OFF_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .reg_sel (in_reg),
        .off     (reg_off),
        .rearm   (rx_rearm),
        .start   (tx_start)
    );

    always_comb begin
        txbuf_we = in_win && host_wr;
        rxbuf_oe = in_win && host_rd;
        buf_act  = in_win && (host_wr || host_rd);
    end

    // R8
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_rearm && tx_start));

    // R4
    buf_act_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_act |-> (txbuf_we || rxbuf_oe));

    // R7
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata != '0) |-> host_rd);

    // R1
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[ADDR_W-1:ADDR_W-4] != 4'hF) |-> !(buf_act || txbuf_we || rxbuf_oe));

endmodule

// File: tb/nic_host_if_tb.sv
module nic_host_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = 16'h0000;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        rx_full = 1'b0;
    logic        tx_busy = 1'b0;
    logic [15:0] rx_len = 16'h0000;
    logic        txbuf_we, rxbuf_oe, buf_act, rx_rearm, tx_start;
    logic [7:0]  host_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string pulse_tag = "R11";

    // Reference model state
    bit engaged = 0;
    bit m_rearm = 0;
    bit m_start = 0;

    always #4 clk = ~clk;

    nic_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .rx_full(rx_full), .tx_busy(tx_busy), .rx_len(rx_len),
        .txbuf_we(txbuf_we), .rxbuf_oe(rxbuf_oe), .buf_act(buf_act),
        .host_rdata(host_rdata), .rx_rearm(rx_rearm), .tx_start(tx_start)
    );

    // Behavioural command model, updated on each edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            engaged = 0; m_rearm = 0; m_start = 0;
        end else begin
            m_rearm = !engaged && host_wr && host_addr == 16'hFB00;
            m_start = !engaged && host_wr && host_addr == 16'hFB01;
            if (m_rearm || m_start) engaged = 1;
            else if (!host_wr) engaged = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0d rd=%0d actual=%0h expected=%0h",
                     tag, host_addr, host_wr, host_rd, act, exp);
        end
    endtask

    task automatic compare();
        bit hit, win, regp;
        int exp_rd;
        string rtag;
        hit  = host_addr[15:12] == 4'hF;
        win  = hit && !host_addr[11];
        regp = hit && host_addr[11:8] == 4'hB;
        exp_rd = 0;
        rtag = hit ? "R7" : "R1";
        if (regp && host_addr[7:0] == 8'h00) rtag = "R5";
        if (regp && (host_addr[7:0] == 8'h02 || host_addr[7:0] == 8'h03)) rtag = "R6";
        if (regp && host_rd) begin
            case (host_addr[7:0])
                8'h00: exp_rd = {30'd0, tx_busy, rx_full};
                8'h02: exp_rd = rx_len[7:0];
                8'h03: exp_rd = rx_len[15:8];
                default: exp_rd = 0;
            endcase
        end
        chk(hit ? "R2" : "R1", txbuf_we, win && host_wr);
        chk(hit ? "R3" : "R1", rxbuf_oe, win && host_rd);
        chk(hit ? "R4" : "R1", buf_act, win && (host_wr || host_rd));
        chk(rtag, host_rdata, exp_rd);
        chk(pulse_tag, rx_rearm, m_rearm);
        chk(pulse_tag, tx_start, m_start);
    endtask

    task automatic step(input logic [15:0] a, input bit w, input bit r);
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r;
        rx_full = 1'($urandom); tx_busy = 1'($urandom); rx_len = 16'($urandom);
        #1 compare();
    endtask

    function automatic logic [15:0] pick_addr(input int kind);
        logic [15:0] a;
        a = 16'($urandom);
        case (kind)
            0: a = {5'b11110, a[10:0]};
            1: a = {8'hFB, 5'd0, a[2:0]};
            2: a = {5'b11111, a[10:0]};
            default: if (a[15:12] == 4'hF) a[15] = 1'b0;
        endcase
        return a;
    endfunction

    initial begin
        // R11 reset state
        repeat (3) step(16'hFB00, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1; host_wr = 1'b0;
        #1 compare();

        // R8 basic commands
        pulse_tag = "R8";
        step(16'hFB00, 1, 0); step(16'h0000, 0, 0); step(16'h0000, 0, 0);
        step(16'hFB01, 1, 0); step(16'h0000, 0, 0); step(16'h0000, 0, 0);

        // R9 held strobe, address changes while held
        pulse_tag = "R9";
        step(16'hFB01, 1, 0); step(16'hFB01, 1, 0); step(16'hFB00, 1, 0);
        step(16'hFB01, 1, 0); step(16'hFB01, 0, 0); step(16'hFB00, 1, 0);
        step(16'hFB00, 0, 0); step(16'h0000, 0, 0);

        // R10 non-command writes and command-address reads
        pulse_tag = "R10";
        step(16'hFB02, 1, 0); step(16'hFB03, 0, 0); step(16'hFB80, 1, 0);
        step(16'hFB00, 0, 1); step(16'hFB01, 0, 1); step(16'hEB00, 1, 0);
        step(16'hEB01, 0, 0); step(16'hF000, 0, 0);

        // Boundaries R1..R7
        pulse_tag = "R8";
        step(16'hF7FF, 1, 0); step(16'hF800, 1, 0); step(16'hF7FF, 0, 1);
        step(16'hF800, 0, 1); step(16'hF000, 0, 1); step(16'hEFFF, 0, 1);
        step(16'hFB00, 0, 1); step(16'hFB02, 0, 1); step(16'hFB03, 0, 1);
        step(16'hFB04, 0, 1); step(16'hFBFF, 0, 1); step(16'hFC00, 0, 1);
        step(16'h7B02, 0, 1); step(16'hFB02, 0, 0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom_range(0, 2);
            step(pick_addr($urandom_range(0, 3)), op == 1, op == 2);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule